// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Strobe Controller

This block sits between a simple request port and an asynchronous DRAM that has a multiplexed address bus and active-low row strobe, column strobe, write enable and output enable. It turns each accepted request into a row-open step and a column cycle. After the column cycle the row stays open, so that a later request to the same row needs only a new column cycle. A request to a different row closes the page, waits out precharge and opens the new row. Every timing minimum is given in nanoseconds and converted to whole controller cycles by ceiling division by the clock period.

Refresh requests take priority over new accesses. If a column cycle is already under way, it finishes first. Any open row is then closed, and the controller runs a column-before-row refresh: the column strobe falls while the row strobe is high, then the row strobe falls, and the address pins carry no meaning. Completion is signalled by a one-cycle acknowledge.

The control path is one state machine. Its states are IDLE (precharged, page closed), RCD (row strobe low with the row address, waiting until the column strobe may fall), CAS (column strobe low), OPEN (page open, column strobe high), CLOSE (row strobe high for precharge), RF_CAS (refresh, column strobe low first) and RF_RAS (refresh, both strobes low). The transitions are:
- IDLE to RF_CAS on a refresh request, and IDLE to RCD on a held request.
- RCD to CAS, CAS to OPEN, and RF_CAS to RF_RAS, each when its count expires.
- OPEN to CAS on a same-row request once the page-cycle gap has passed.
- OPEN to CLOSE on a refresh request or a different-row request, once the row-low minimum is met.
- RF_RAS to CLOSE once the row-low minimum is met.
- CLOSE to RF_CAS, RCD or IDLE once precharge and the full-cycle minimum are met.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are all 1. dram_dq_oe and rd_valid are 0, and req_ready is 1 while ref_req is 0.
- R2: req_addr is {row, column}, with the row in the upper ROW_W bits. When dram_ras_n falls for an access, dram_addr carries the row. When dram_cas_n falls, dram_addr carries the column, zero-extended. Requests are served in acceptance order.
- R3: For an access, dram_cas_n falls no fewer than ceil(T_RCD_NS/CLK_PERIOD_NS) cycles after dram_ras_n falls.
- R4: Each low pulse of dram_ras_n lasts at least ceil(T_RAS_NS/period) cycles. Each high period before a fall lasts at least ceil(T_RP_NS/period) cycles. Successive falls are at least ceil(T_RC_NS/period) cycles apart.
- R5: Each low pulse of dram_cas_n lasts at least ceil(T_CAS_NS/period) cycles. Within one open row, successive falls of dram_cas_n are at least ceil(T_PC_NS/period) cycles apart, and back-to-back same-row requests achieve exactly that spacing.
- R6: For a write (req_write=1), dram_we_n is 0 and dram_oe_n is 1 while dram_cas_n is low, and dram_dq_oe is 1 with dram_dq_out equal to the request's write data. dram_dq_oe is never 1 while dram_we_n is 1.
- R7: For a read, dram_we_n is 1 and dram_oe_n is 0 while dram_cas_n is low, and dram_oe_n is low only then. The value on dram_dq_in in the last cycle of the column pulse appears on rd_data with a one-cycle rd_valid pulse, in request order.
- R8: A request to the row that is already open causes no edge on dram_ras_n.
- R9: A request to a different row raises dram_ras_n, precharges, and lowers dram_ras_n again with the new row. Each such access costs exactly one fall of dram_ras_n.
- R10: While ref_req is 1, the controller runs one refresh. dram_cas_n falls while dram_ras_n is 1, then dram_ras_n falls while dram_cas_n stays 0, then both return high. ref_ack pulses for exactly one cycle per refresh.
- R11: While ref_req is 1, req_ready is 0. A column cycle in progress completes first, and an open row is closed before the refresh. The next access after the refresh reopens its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on a cycle with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | {row, column} |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh request, held until ref_ack |
| ref_ack | output | 1 | One-cycle refresh completion |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
The bench pairs a behavioural DRAM model with a per-cycle strobe monitor. Together they measure every pulse width, precharge gap, full-cycle gap, row-to-column delay and page-cycle spacing. A controller that left any count one cycle short would show up as a shortened pulse. Same-row bursts are checked for the absence of row-strobe edges and for exact page-cycle throughput, so a design that reopened the row or inserted idle cycles would fail. Alternating-row accesses with data that depends on the row would expose a stale or wrongly multiplexed row address. The refresh runs twice: once with a column strobe already low, which catches a refresh that cuts a column cycle short, and once on an idle open page, which catches a page left open across the refresh and a missing or repeated acknowledge.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_CAS,
        ST_OPEN,
        ST_CLOSE,
        ST_RF_CAS,
        ST_RF_RAS
    } ctrl_state_e;

    // Whole cycles covering a minimum time, never fewer than one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // States in which the row strobe is held low.
    function automatic logic row_low(input ctrl_state_e s);
        return (s == ST_RCD) || (s == ST_CAS) || (s == ST_OPEN) || (s == ST_RF_RAS);
    endfunction

endpackage

// File: rtl/dram_cyc_timer.sv
module dram_cyc_timer #(
    parameter int MAX     = 8,
    parameter int RST_VAL = 0,
    parameter int W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP  = W'(MAX);
    localparam logic [W-1:0] INIT = W'(RST_VAL);

    // Saturating up-counter; clear restarts it at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= INIT;
        end else if (clear) begin
            count <= '0;
        end else if (count < TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dram_req_hold.sv
module dram_req_hold #(
    parameter int ROW_W = 10,
    parameter int COL_W = 8,
    parameter int DQ_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    input  logic                   done,
    input  logic                   latch_row,
    output logic                   cur_v,
    output logic                   cur_wr,
    output logic [ROW_W-1:0]       cur_row,
    output logic [COL_W-1:0]       cur_col,
    output logic [DQ_W-1:0]        cur_wdata,
    output logic                   page_hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_v     <= 1'b0;
            cur_wr    <= 1'b0;
            cur_row   <= '0;
            cur_col   <= '0;
            cur_wdata <= '0;
        end else if (take) begin
            cur_v     <= 1'b1;
            cur_wr    <= req_write;
            cur_row   <= req_addr[ROW_W+COL_W-1:COL_W];
            cur_col   <= req_addr[COL_W-1:0];
            cur_wdata <= req_wdata;
        end else if (done) begin
            cur_v     <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_row <= '0;
        end else if (latch_row) begin
            open_row <= cur_row;
        end
    end

    assign page_hit = cur_v && (cur_row == open_row);

    // R2: a request is never taken while another is still held
    a_r2_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !cur_v);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_page_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RCD_NS      = 11,
    parameter int T_RAS_NS      = 50,
    parameter int T_RP_NS       = 30,
    parameter int T_RC_NS       = 84,
    parameter int T_CAS_NS      = 8,
    parameter int T_PC_NS       = 20,
    parameter int T_CSR_NS      = 5,
    parameter int ROW_W         = 10,
    parameter int COL_W         = 8,
    parameter int DQ_W          = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                req_write,
    input  logic [ROW_W+COL_W-1:0]              req_addr,
    input  logic [DQ_W-1:0]                     req_wdata,
    output logic                                rd_valid,
    output logic [DQ_W-1:0]                     rd_data,
    input  logic                                ref_req,
    output logic                                ref_ack,
    output logic                                dram_ras_n,
    output logic                                dram_cas_n,
    output logic                                dram_we_n,
    output logic                                dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DQ_W-1:0]                     dram_dq_out,
    output logic                                dram_dq_oe,
    input  logic [DQ_W-1:0]                     dram_dq_in
);
    localparam int AW     = max2(ROW_W, COL_W);
    localparam int RCD_C  = ns_to_cycles(T_RCD_NS, CLK_PERIOD_NS);
    localparam int RAS_C  = ns_to_cycles(T_RAS_NS, CLK_PERIOD_NS);
    localparam int RP_C   = ns_to_cycles(T_RP_NS,  CLK_PERIOD_NS);
    localparam int RC_C   = max2(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS), RAS_C + RP_C);
    localparam int CAS_C  = ns_to_cycles(T_CAS_NS, CLK_PERIOD_NS);
    localparam int PC_C   = ns_to_cycles(T_PC_NS,  CLK_PERIOD_NS);
    localparam int CASH_C = max2(1, PC_C - CAS_C);
    localparam int CSR_C  = ns_to_cycles(T_CSR_NS, CLK_PERIOD_NS);
    localparam int SAT    = max2(RC_C, max2(CASH_C, max2(CSR_C, max2(RCD_C, CAS_C))));
    localparam int CW     = $clog2(SAT + 2);

    localparam logic [CW-1:0] RCD_L  = CW'(RCD_C - 1);
    localparam logic [CW-1:0] RAS_L  = CW'(RAS_C - 1);
    localparam logic [CW-1:0] RP_L   = CW'(RP_C - 1);
    localparam logic [CW-1:0] RC_L   = CW'(RC_C - 1);
    localparam logic [CW-1:0] CAS_L  = CW'(CAS_C - 1);
    localparam logic [CW-1:0] CASH_L = CW'(CASH_C - 1);
    localparam logic [CW-1:0] CSR_L  = CW'(CSR_C - 1);

    ctrl_state_e      state, state_d;
    logic [CW-1:0]    st_cnt;
    logic [CW-1:0]    since_fall;
    logic             take;
    logic             col_done;
    logic             row_enter;
    logic             cur_v, cur_wr, page_hit;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [DQ_W-1:0]  cur_wdata;

    assign req_ready = !cur_v && !ref_req;
    assign take      = req_valid && req_ready;
    assign col_done  = (state == ST_CAS) && (state_d == ST_OPEN);
    assign row_enter = (state_d == ST_RCD) && (state != ST_RCD);

    dram_req_hold #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DQ_W  (DQ_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done      (col_done),
        .latch_row (row_enter),
        .cur_v     (cur_v),
        .cur_wr    (cur_wr),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .cur_wdata (cur_wdata),
        .page_hit  (page_hit)
    );

    // Cycles spent in the present state.
    dram_cyc_timer #(.MAX(SAT), .RST_VAL(0), .W(CW)) u_st_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state),
        .count (st_cnt)
    );

    // Cycles since the row strobe last fell; starts satisfied.
    dram_cyc_timer #(.MAX(SAT), .RST_VAL(SAT), .W(CW)) u_rc_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (row_low(state_d) && !row_low(state)),
        .count (since_fall)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Transitions.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_req)    state_d = ST_RF_CAS;
                else if (cur_v) state_d = ST_RCD;
            end
            ST_RCD: begin
                if (st_cnt >= RCD_L) state_d = ST_CAS;
            end
            ST_CAS: begin
                if (st_cnt >= CAS_L) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_req || (cur_v && !page_hit)) begin
                    if (since_fall >= RAS_L) state_d = ST_CLOSE;
                end else if (cur_v && (st_cnt >= CASH_L)) begin
                    state_d = ST_CAS;
                end
            end
            ST_CLOSE: begin
                if ((st_cnt >= RP_L) && (since_fall >= RC_L)) begin
                    if (ref_req)    state_d = ST_RF_CAS;
                    else if (cur_v) state_d = ST_RCD;
                    else            state_d = ST_IDLE;
                end
            end
            ST_RF_CAS: begin
                if (st_cnt >= CSR_L) state_d = ST_RF_RAS;
            end
            ST_RF_RAS: begin
                if (since_fall >= RAS_L) state_d = ST_CLOSE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered strobes and results, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            ref_ack     <= 1'b0;
        end else begin
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_addr   <= '0;
            dram_dq_oe  <= 1'b0;
            rd_valid    <= col_done && !cur_wr;
            ref_ack     <= (state == ST_RF_RAS) && (state_d == ST_CLOSE);
            if (col_done && !cur_wr) rd_data <= dram_dq_in;
            unique case (state_d)
                ST_IDLE, ST_CLOSE: begin
                end
                ST_RCD: begin
                    dram_ras_n <= 1'b0;
                    dram_addr  <= AW'(cur_row);
                end
                ST_CAS: begin
                    dram_ras_n  <= 1'b0;
                    dram_cas_n  <= 1'b0;
                    dram_we_n   <= !cur_wr;
                    dram_oe_n   <= cur_wr;
                    dram_addr   <= AW'(cur_col);
                    dram_dq_oe  <= cur_wr;
                    dram_dq_out <= cur_wdata;
                end
                ST_OPEN: begin
                    dram_ras_n <= 1'b0;
                end
                ST_RF_CAS: begin
                    dram_cas_n <= 1'b0;
                end
                ST_RF_RAS: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

    // Pulse-width counters observed on the pins, for the assertions.
    logic [CW-1:0] ras_lo_q, ras_hi_q, cas_lo_q;
    localparam logic [CW-1:0] SAT_L = CW'(SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_q <= '0;
            ras_hi_q <= SAT_L;
            cas_lo_q <= '0;
        end else begin
            ras_lo_q <= dram_ras_n ? '0 : ((ras_lo_q < SAT_L) ? ras_lo_q + 1'b1 : ras_lo_q);
            ras_hi_q <= !dram_ras_n ? '0 : ((ras_hi_q < SAT_L) ? ras_hi_q + 1'b1 : ras_hi_q);
            cas_lo_q <= dram_cas_n ? '0 : ((cas_lo_q < SAT_L) ? cas_lo_q + 1'b1 : cas_lo_q);
        end
    end

    a_r3_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> ($past(ras_lo_q) >= RCD_L));

    a_r4_row_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ($past(ras_lo_q) >= RAS_L));

    a_r4_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> ($past(ras_hi_q) >= RP_L));

    a_r5_col_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> ($past(cas_lo_q) >= CAS_L));

    a_r6_drive_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n && !dram_cas_n));

    a_r7_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> (!dram_ras_n && !dram_cas_n && dram_we_n));

    a_r10_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && dram_cas_n));

    a_r11_no_take_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !req_ready);
endmodule

// File: tb/dram_page_ctrl_test.sv
`timescale 1ns/1ps
module dram_page_ctrl_test;
    localparam int CLK_NS = 4;
    localparam int B_RCD  = (11 + CLK_NS - 1) / CLK_NS;
    localparam int B_RAS  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int B_RP   = (30 + CLK_NS - 1) / CLK_NS;
    localparam int B_RC   = (84 + CLK_NS - 1) / CLK_NS;
    localparam int B_CAS  = (8  + CLK_NS - 1) / CLK_NS;
    localparam int B_PC   = (20 + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ref_req = 1'b0;
    logic        ref_ack;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [9:0]  dram_addr;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = 16'hBAD0;

    always #2 clk = ~clk;

    dram_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference state: expected memory, issued requests, expected reads.
    int exp_mem [int];
    int dmem    [int];
    int iq_row[$], iq_col[$], iq_wr[$], iq_dat[$];
    int rq[$];

    // Pin monitor and DRAM model, sampled once per clock away from the edge.
    int cyc = 0;
    int last_fall = -1000, last_rise = -1000, last_cfall = -1000, last_crise = -1000;
    int row_l = 0, col_l = 0;
    int norm_falls = 0, cbr_falls = 0, ack_cnt = 0, gap_last = 0;
    bit cbr_armed = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                chk(cyc - last_rise >= B_RP, "R4", "precharge cycles", cyc - last_rise, B_RP);
                chk(cyc - last_fall >= B_RC, "R4", "row cycle", cyc - last_fall, B_RC);
                if (!dram_cas_n) begin
                    chk(cbr_armed, "R10", "column fell before row", cbr_armed, 1);
                    cbr_falls++;
                end else begin
                    norm_falls++;
                    row_l = int'(dram_addr);
                end
                cbr_armed = 0;
                last_fall = cyc;
            end
            if (!p_ras && dram_ras_n) begin
                chk(cyc - last_fall >= B_RAS, "R4", "row low cycles", cyc - last_fall, B_RAS);
                last_rise = cyc;
            end
            if (p_cas && !dram_cas_n) begin
                if (dram_ras_n) begin
                    cbr_armed = 1;
                end else begin
                    chk(cyc - last_fall >= B_RCD, "R3", "row to column", cyc - last_fall, B_RCD);
                    if (last_cfall > last_fall) begin
                        gap_last = cyc - last_cfall;
                        chk(gap_last >= B_PC, "R5", "page cycle", gap_last, B_PC);
                    end
                    col_l = int'(dram_addr);
                    if (iq_row.size() == 0) begin
                        chk(0, "R2", "column cycle without request", 0, 1);
                    end else begin
                        int er, ec, ew, ed;
                        er = iq_row.pop_front(); ec = iq_col.pop_front();
                        ew = iq_wr.pop_front();  ed = iq_dat.pop_front();
                        chk(row_l == er, "R2", "row address", row_l, er);
                        chk(col_l == ec, "R2", "column address", col_l, ec);
                        if (ew != 0) begin
                            chk(!dram_we_n && dram_oe_n, "R6", "write strobes", dram_we_n, 0);
                            chk(dram_dq_oe && int'(dram_dq_out) == ed, "R6", "write data",
                                int'(dram_dq_out), ed);
                            dmem[row_l*256 + col_l] = int'(dram_dq_out);
                        end else begin
                            chk(dram_we_n && !dram_oe_n, "R7", "read strobes", dram_oe_n, 0);
                        end
                    end
                end
                last_cfall = cyc;
            end
            if (!p_cas && dram_cas_n) begin
                chk(cyc - last_cfall >= B_CAS, "R5", "column low cycles", cyc - last_cfall, B_CAS);
                last_crise = cyc;
            end
            if (!dram_oe_n)
                chk(!dram_ras_n && !dram_cas_n && dram_we_n, "R7", "output enable window", 0, 1);
            if (dram_dq_oe)
                chk(!dram_we_n && dram_oe_n, "R6", "drive without write", dram_we_n, 0);
            if (rd_valid) begin
                if (rq.size() == 0) begin
                    chk(0, "R7", "unexpected read data", int'(rd_data), -1);
                end else begin
                    int e;
                    e = rq.pop_front();
                    chk(int'(rd_data) == e, "R7", "read data", int'(rd_data), e);
                end
            end
            if (ref_ack) ack_cnt++;
        end
        // DRAM model read path.
        if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
            dram_dq_in <= dmem.exists(row_l*256 + col_l) ? 16'(dmem[row_l*256 + col_l]) : 16'h0;
        else
            dram_dq_in <= 16'hBAD0;
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
    end

    task automatic issue(input int row, input int col, input bit wr, input int data);
        req_addr  = 18'(row * 256 + col);
        req_write = wr;
        req_wdata = 16'(data);
        req_valid = 1'b1;
        #0.1;
        while (!req_ready) begin
            @(negedge clk);
            #0.1;
        end
        iq_row.push_back(row); iq_col.push_back(col);
        iq_wr.push_back(wr ? 1 : 0); iq_dat.push_back(data);
        if (wr) exp_mem[row*256 + col] = data;
        else    rq.push_back(exp_mem.exists(row*256 + col) ? exp_mem[row*256 + col] : 0);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while ((iq_row.size() != 0 || rq.size() != 0) && !done) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic refresh_once();
        ref_req = 1'b1;
        #0.1;
        chk(!req_ready, "R11", "ready during refresh request", req_ready, 0);
        while (!ref_ack && !done) @(negedge clk);
        ref_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int f0, c0, a0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes idle high",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !rd_valid, "R1", "no drive, no read", dram_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);

        // R6/R8: same-row writes then reads, one row opening in total
        f0 = norm_falls;
        for (int i = 0; i < 4; i++) issue(5, i, 1, 16'h1100 + i * 7);
        for (int i = 0; i < 4; i++) issue(5, i, 0, 0);
        drain();
        chk(norm_falls - f0 == 1, "R8", "row openings for same-row burst", norm_falls - f0, 1);
        chk(gap_last == B_PC, "R5", "back-to-back page spacing", gap_last, B_PC);

        // R9: alternating rows, row-dependent data
        issue(9, 2, 1, 16'h9902);
        issue(5, 2, 1, 16'h5502);
        drain();
        f0 = norm_falls;
        issue(9, 2, 0, 0);
        issue(5, 2, 0, 0);
        issue(9, 2, 0, 0);
        drain();
        chk(norm_falls - f0 == 3, "R9", "row openings for alternating rows", norm_falls - f0, 3);

        // R10/R11: refresh with a page open and idle
        c0 = cbr_falls; a0 = ack_cnt; f0 = norm_falls;
        refresh_once();
        repeat (3) @(negedge clk);
        chk(cbr_falls - c0 == 1, "R10", "refresh cycles run", cbr_falls - c0, 1);
        chk(ack_cnt - a0 == 1, "R10", "acknowledge pulses", ack_cnt - a0, 1);
        chk(norm_falls == f0, "R10", "no access row opening", norm_falls - f0, 0);
        issue(9, 2, 0, 0);
        drain();
        chk(norm_falls - f0 == 1, "R11", "row reopened after refresh", norm_falls - f0, 1);

        // R11: refresh raised while a column cycle is under way
        c0 = cbr_falls; a0 = ack_cnt;
        issue(9, 3, 1, 16'h7733);
        while (dram_cas_n && !done) @(negedge clk);
        refresh_once();
        drain();
        issue(9, 3, 0, 0);
        drain();
        chk(cbr_falls - c0 == 1, "R11", "refresh after column cycle", cbr_falls - c0, 1);
        chk(ack_cnt - a0 == 1, "R10", "one acknowledge", ack_cnt - a0, 1);
        chk(rq.size() == 0 && iq_row.size() == 0, "R7", "all requests served",
            rq.size() + iq_row.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            done = 1;
            chk(0, "R1", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule